// File: doc/BRIEF.md
# CPU Clock Divider and Source Selector

This block produces the processor clock from two reference clocks, a fast PLL clock and a slower crystal clock. A first glitch-free selector picks which reference feeds a ratio divider. The divider divides by 1, 2 or 3, or by an even ratio of twice a programmable multiplier. A second glitch-free selector then routes either the divided clock or the raw crystal clock to the processor.

Software controls the block through two 32-bit registers on a simple synchronous read/write bus. Before it retunes the PLL, software parks the processor on the crystal: it clears the output selector, waits for that to settle, and then points the divider input at the PLL. Once the PLL is stable it sets the output selector back to the divider and waits again. The block does not time these settle periods itself. A new ratio takes effect only when the current output period ends, so the processor clock never has a truncated phase.

Top module: `cpuclk_divmux`

## Requirements
- R1: After reset both registers read 0 and the processor clock follows the crystal clock.
- R2: The control register sits at byte offset 0x40 and the multiplier register at 0x00. Every one of the 32 bits of each register reads back as written, and any other offset reads 0.
- R3: Control bit 7 selects the output. When it is 0 the processor clock is the crystal clock, whatever the divider is set to. When it is 1 the processor clock is the divider output.
- R4: Control bit 0 selects the divider input. 1 selects the PLL clock and 0 selects the crystal clock.
- R5: The 2-bit ratio code in control bits 3:2 divides by 1, 2 or 3 for codes 0, 1 and 2. A divide-by-3 output is high for one input period and low for two. A divide-by-2 output is high for one input period and low for one.
- R6: Ratio code 3 divides by 2×M, where M is the 9-bit multiplier in bits 28:20 of the multiplier register. The output is high for M input periods and low for M.
- R7: Ratio code 3 with M = 0 divides by 2 and does not stop the clock.
- R8: A change to the ratio code or the multiplier takes effect only at the end of the current output period. No phase of the divided clock is cut short while the ratio changes.
- R9: Neither selector ever enables both of its inputs at once. The processor clock never shows a phase shorter than half the period of the faster reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_clk | input | 1 | Fast PLL reference clock |
| xtal_clk | input | 1 | Crystal reference clock |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Bus write enable (1 = write) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from the address) |
| cpu_clk | output | 1 | Processor clock |

## Verification
The bench measures the high and low widths of the processor clock after each setting. It covers each ratio code on the PLL and on the crystal, a non-zero and a zero multiplier, and the parked state with the divider already set up. Unequal high and low widths tell divide-by-3 apart from the even ratios. The two reference periods are not multiples of each other, which separates a wrong source choice from a wrong ratio. A ratio change made while the clock runs is watched for any phase shorter than one PLL period, which would show a truncated phase. A running minimum over every edge of the whole run exposes a runt pulse left by either selector.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;
    localparam int unsigned BUS_AW      = 8;
    localparam int unsigned BUS_DW      = 32;
    localparam int unsigned CODE_W      = 2;
    localparam int unsigned MULT_W      = 9;
    localparam int unsigned CODE_LSB    = 2;
    localparam int unsigned MULT_LSB    = 20;
    localparam int unsigned OUT_SEL_BIT = 7;
    localparam int unsigned SRC_SEL_BIT = 0;
    localparam logic [7:0]  OFF_CTRL    = 8'h40;
    localparam logic [7:0]  OFF_MULT    = 8'h00;

    typedef enum logic [1:0] {
        CODE_DIV1 = 2'd0,
        CODE_DIV2 = 2'd1,
        CODE_DIV3 = 2'd2,
        CODE_EVEN = 2'd3
    } ratio_code_e;
endpackage

// File: rtl/cpuclk_regs.sv
module cpuclk_regs
    import cpuclk_pkg::*;
#(
    parameter int unsigned AW = BUS_AW,
    parameter int unsigned DW = BUS_DW,
    parameter int unsigned CW = CODE_W,
    parameter int unsigned NW = MULT_W,
    parameter logic [AW-1:0] CTRL_OFF = AW'(OFF_CTRL),
    parameter logic [AW-1:0] MULT_OFF = AW'(OFF_MULT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          out_sel_o,
    output logic          src_sel_o,
    output logic [CW-1:0] code_o,
    output logic [NW-1:0] mult_o
);
    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [DW-1:0] mult;
    } regs_t;

    regs_t r_d, r_q;
    logic  hit_ctrl, hit_mult;

    always_comb begin
        hit_ctrl = bus_sel && bus_we && (bus_addr == CTRL_OFF);
        hit_mult = bus_sel && bus_we && (bus_addr == MULT_OFF);
        r_d = r_q;
        if (hit_ctrl) r_d.ctrl = bus_wdata;
        if (hit_mult) r_d.mult = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_OFF)      bus_rdata = r_q.ctrl;
        else if (bus_addr == MULT_OFF) bus_rdata = r_q.mult;
    end

    assign out_sel_o = r_q.ctrl[OUT_SEL_BIT];
    assign src_sel_o = r_q.ctrl[SRC_SEL_BIT];
    assign code_o    = r_q.ctrl[CODE_LSB +: CW];
    assign mult_o    = r_q.mult[MULT_LSB +: NW];

    // R2: a write to the control offset is visible on the read port next cycle
    a_r2_ctrl_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == CTRL_OFF) |=> (r_q.ctrl == $past(bus_wdata)));

    // R2: a write to the multiplier offset lands whole
    a_r2_mult_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == MULT_OFF) |=> (r_q.mult == $past(bus_wdata)));
endmodule

// File: rtl/cpuclk_gmux.sv
module cpuclk_gmux #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst_n,
    input  logic sel,
    output logic clk_o
);
    localparam int unsigned SL = SYNC_STAGES - 1;

    logic [SL:0] sa_d, sa_q, sb_d, sb_q;
    logic        ena_d, ena_q, enb_d, enb_q;

    always_comb begin
        sa_d  = {sa_q[SL-1:0], ~sel & ~enb_q};
        sb_d  = {sb_q[SL-1:0],  sel & ~ena_q};
        ena_d = sa_q[SL];
        enb_d = sb_q[SL];
    end

    // synchronizers run on rising edges, enables change on falling edges
    always_ff @(posedge clk_a or negedge rst_n) begin
        if (!rst_n) sa_q <= '1;
        else        sa_q <= sa_d;
    end

    always_ff @(negedge clk_a or negedge rst_n) begin
        if (!rst_n) ena_q <= 1'b1;
        else        ena_q <= ena_d;
    end

    always_ff @(posedge clk_b or negedge rst_n) begin
        if (!rst_n) sb_q <= '0;
        else        sb_q <= sb_d;
    end

    always_ff @(negedge clk_b or negedge rst_n) begin
        if (!rst_n) enb_q <= 1'b0;
        else        enb_q <= enb_d;
    end

    assign clk_o = (clk_a & ena_q) | (clk_b & enb_q);

    // R9: the two inputs are never enabled together
    a_r9_excl_on_a: assert property (@(posedge clk_a) disable iff (!rst_n)
        !(ena_q && enb_q));
    a_r9_excl_on_b: assert property (@(posedge clk_b) disable iff (!rst_n)
        !(ena_q && enb_q));
endmodule

// File: rtl/cpuclk_div.sv
module cpuclk_div
    import cpuclk_pkg::*;
#(
    parameter int unsigned CW = CODE_W,
    parameter int unsigned NW = MULT_W
) (
    input  logic          clk_i,
    input  logic          rst_n,
    input  logic [CW-1:0] code_i,
    input  logic [NW-1:0] mult_i,
    output logic          clk_o
);
    localparam int unsigned RW = NW + 1;
    localparam int unsigned FW = CW + NW;

    typedef struct packed {
        logic [FW-1:0] s1;
        logic [FW-1:0] s2;
        logic [RW-1:0] cnt;
        logic [RW-1:0] ratio;
        logic          out;
        logic          byp;
    } div_t;

    div_t d_d, d_q;
    logic last;

    function automatic logic [RW-1:0] ratio_of(input logic [FW-1:0] cfg);
        logic [CW-1:0] c;
        logic [NW-1:0] m;
        c = cfg[FW-1 -: CW];
        m = cfg[NW-1:0];
        if (c != CW'(CODE_EVEN)) ratio_of = RW'(c) + RW'(1);
        else if (m == '0)        ratio_of = RW'(2);
        else                     ratio_of = {m, 1'b0};
    endfunction

    always_comb begin
        d_d    = d_q;
        d_d.s1 = {code_i, mult_i};
        d_d.s2 = d_q.s1;
        last   = (d_q.cnt == d_q.ratio - RW'(1));
        if (last) begin
            d_d.cnt   = '0;
            d_d.ratio = ratio_of(d_q.s2);
        end else begin
            d_d.cnt   = d_q.cnt + RW'(1);
        end
        d_d.out = (d_d.cnt < (d_d.ratio >> 1));
        d_d.byp = (d_d.ratio == RW'(1));
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            d_q       <= '0;
            d_q.ratio <= RW'(1);
            d_q.byp   <= 1'b1;
        end else begin
            d_q <= d_d;
        end
    end

    assign clk_o = d_q.byp ? clk_i : d_q.out;

    // R8: the ratio holds for the whole output period
    a_r8_ratio_holds: assert property (@(posedge clk_i) disable iff (!rst_n)
        (d_q.cnt != '0) |-> $stable(d_q.ratio));

    // R5: the phase counter stays inside the active ratio
    a_r5_count_range: assert property (@(posedge clk_i) disable iff (!rst_n)
        d_q.cnt < d_q.ratio);

    // R7: a zero ratio is never loaded
    a_r7_ratio_nonzero: assert property (@(posedge clk_i) disable iff (!rst_n)
        d_q.ratio != '0);
endmodule

// File: rtl/cpuclk_divmux.sv
module cpuclk_divmux
    import cpuclk_pkg::*;
#(
    parameter int unsigned AW = BUS_AW,
    parameter int unsigned DW = BUS_DW,
    parameter int unsigned CW = CODE_W,
    parameter int unsigned NW = MULT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pll_clk,
    input  logic          xtal_clk,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          cpu_clk
);
    logic          out_sel, src_sel;
    logic [CW-1:0] code;
    logic [NW-1:0] mult;
    logic          src_clk, div_clk;

    cpuclk_regs #(.AW(AW), .DW(DW), .CW(CW), .NW(NW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .out_sel_o (out_sel),
        .src_sel_o (src_sel),
        .code_o    (code),
        .mult_o    (mult)
    );

    cpuclk_gmux u_src_mux (
        .clk_a (xtal_clk),
        .clk_b (pll_clk),
        .rst_n (rst_n),
        .sel   (src_sel),
        .clk_o (src_clk)
    );

    cpuclk_div #(.CW(CW), .NW(NW)) u_div (
        .clk_i  (src_clk),
        .rst_n  (rst_n),
        .code_i (code),
        .mult_i (mult),
        .clk_o  (div_clk)
    );

    cpuclk_gmux u_out_mux (
        .clk_a (xtal_clk),
        .clk_b (div_clk),
        .rst_n (rst_n),
        .sel   (out_sel),
        .clk_o (cpu_clk)
    );
endmodule

// File: tb/sim_cpuclk_divmux.sv
`timescale 1ns/1ps
module sim_cpuclk_divmux;
    localparam real PLL_P  = 6.0;
    localparam real XTAL_P = 20.0;
    localparam logic [7:0] A_CTRL = 8'h40;
    localparam logic [7:0] A_MULT = 8'h00;

    logic        clk = 1'b0, pll_clk = 1'b0, xtal_clk = 1'b0, rst_n = 1'b1;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_clk;

    int total = 0, bad = 0;
    // bench model state: what software has programmed
    int m_out = 0, m_src = 0, m_code = 0, m_mult = 0;
    realtime last_edge = 0.0, glob_min = 1.0e9, win_min = 1.0e9;
    bit mon_on = 0, win_on = 0;

    cpuclk_divmux u0 (
        .clk(clk), .rst_n(rst_n), .pll_clk(pll_clk), .xtal_clk(xtal_clk),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_clk(cpu_clk)
    );

    always #2  clk = ~clk;
    always #3  pll_clk = ~pll_clk;
    always #10 xtal_clk = ~xtal_clk;

    // phase-width monitor over every processor clock edge
    always @(cpu_clk) begin
        if (mon_on) begin
            if ($realtime - last_edge < glob_min) glob_min = $realtime - last_edge;
            if (win_on && ($realtime - last_edge < win_min)) win_min = $realtime - last_edge;
        end
        last_edge = $realtime;
    end

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_near(input string tag, input real act, input real exp);
        real d;
        d = act - exp;
        if (d < 0.0) d = -d;
        total++;
        if (d > 0.05) begin
            bad++;
            $display("FAIL %s: actual=%0.3f ns expected=%0.3f ns", tag, act, exp);
        end
    endtask

    task automatic check_min(input string tag, input real act, input real floor);
        total++;
        if (act < floor - 0.05) begin
            bad++;
            $display("FAIL %s: actual min phase=%0.3f ns expected>=%0.3f ns", tag, act, floor);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] ctrl_word();
        return (32'(m_out) << 7) | (32'(m_code) << 2) | 32'(m_src);
    endfunction

    // behavioural model of the expected high and low widths
    task automatic expect_phases(output real hi, output real lo);
        real p;
        int  r;
        if (m_out == 0) begin
            hi = XTAL_P / 2.0; lo = XTAL_P / 2.0;
        end else begin
            p = (m_src != 0) ? PLL_P : XTAL_P;
            if (m_code < 3)      r = m_code + 1;
            else if (m_mult == 0) r = 2;
            else                 r = 2 * m_mult;
            if (r == 1) begin
                hi = p / 2.0; lo = p / 2.0;
            end else begin
                hi = p * (r / 2); lo = p * (r - r / 2);
            end
        end
    endtask

    task automatic measure(input string tag);
        realtime t0, t1, t2;
        real hi, lo;
        expect_phases(hi, lo);
        repeat (2) @(posedge cpu_clk);
        for (int k = 0; k < 2; k++) begin
            @(posedge cpu_clk); t0 = $realtime;
            @(negedge cpu_clk); t1 = $realtime;
            @(posedge cpu_clk); t2 = $realtime;
            check_near({tag, " high"}, t1 - t0, hi);
            check_near({tag, " low"},  t2 - t1, lo);
        end
    endtask

    // park on crystal, retarget, then return to the divider
    task automatic program_cfg(input int src, input int code, input int mult);
        m_out = 0;
        bus_write(A_CTRL, ctrl_word());
        #300;
        m_mult = mult;
        bus_write(A_MULT, 32'(mult) << 20);
        m_src = src; m_code = code;
        bus_write(A_CTRL, ctrl_word());
        #300;
        m_out = 1;
        bus_write(A_CTRL, ctrl_word());
        #1200;
    endtask

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        #1 rst_n = 1'b0;
        #100;
        @(negedge clk);
        rst_n = 1'b1;
        last_edge = $realtime;
        mon_on = 1;

        // R1: reset state
        bus_read(A_CTRL, rd); check_eq("R1 ctrl after reset", rd, 32'h0);
        bus_read(A_MULT, rd); check_eq("R1 mult after reset", rd, 32'h0);
        #200;
        measure("R1 crystal after reset");

        // R2: full-width readback and unmapped offset
        bus_write(A_MULT, 32'hFFFF_FFFF);
        bus_read(A_MULT, rd); check_eq("R2 mult readback", rd, 32'hFFFF_FFFF);
        bus_write(A_CTRL, 32'h7A5A_5A00);
        bus_read(A_CTRL, rd); check_eq("R2 ctrl readback", rd, 32'h7A5A_5A00);
        bus_read(8'h20, rd); check_eq("R2 unmapped reads 0", rd, 32'h0);
        bus_write(A_CTRL, 32'h0);
        bus_write(A_MULT, 32'h0);

        // R3: divider set up on the PLL but output parked on the crystal
        m_src = 1; m_code = 1; m_out = 0;
        bus_write(A_CTRL, ctrl_word());
        #600;
        measure("R3 parked on crystal");

        program_cfg(1, 0, 0); measure("R4 R5 pll div1");
        program_cfg(1, 1, 0); measure("R5 pll div2");
        program_cfg(1, 2, 0); measure("R5 pll div3");
        program_cfg(1, 3, 5); measure("R6 pll even M=5");
        program_cfg(1, 3, 0); measure("R7 pll even M=0");
        program_cfg(0, 2, 0); measure("R4 xtal div3");
        program_cfg(0, 3, 2); measure("R6 xtal even M=2");

        // R8: change the ratio while the divided clock is running
        program_cfg(1, 3, 4); measure("R6 pll even M=4");
        win_min = 1.0e9; win_on = 1;
        m_code = 1;
        bus_write(A_CTRL, ctrl_word());
        #600;
        win_on = 0;
        check_min("R8 no truncated phase on live change", win_min, PLL_P);
        measure("R8 new ratio after live change");

        // R9: no runt pulse anywhere in the run
        check_min("R9 global minimum phase", glob_min, PLL_P / 2.0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule